// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block turns one 6-bit operand code of a 16-bit, word-addressed processor into everything the execute stage needs to read or write that operand. It receives the code together with the eight general registers, the stack pointer, the program counter, the overflow register, the word that follows the instruction in the code stream, and the data returned by a one-word memory read port. From these it reports the operand class, the register or special-register index, the effective memory address, the operand value, whether the following code word is consumed, and the program counter and stack pointer that result.

The decode path is purely combinational. The stack pointer change for pop and push codes is also held in a register, which loads only when the sequencer raises a commit strobe. The sequencer can therefore read an operand speculatively and apply the stack movement only when the instruction executes. Literal and inline-immediate operands carry a discard flag, so that a write-back aimed at them is dropped.

Top module: `operand_decoder`

## Requirements
- R1: Codes 0x00 to 0x07 give class GPR (kind = 0), gpr_idx = code[2:0] and the value of that general register. Register k sits at gpr_flat[16k+15:16k].
- R2: Codes 0x08 to 0x0F give class MEM (kind = 1), mem_rd = 1, and a memory address equal to general register code[2:0]. The value is the word returned on mem_rdata.
- R3: Codes 0x10 to 0x17 give class MEM at address general register code[2:0] plus ext_word, taken modulo 2^16. They set uses_ext = 1 and pc_next = pc_in + 1.
- R4: Code 0x18 (pop) gives class MEM at address sp_in and sp_next = sp_in + 1 modulo 2^16.
- R5: Code 0x19 (peek) gives class MEM at address sp_in and sp_next = sp_in.
- R6: Code 0x1A (push) gives class MEM at address sp_in - 1 modulo 2^16 and sp_next = sp_in - 1.
- R7: Codes 0x1B, 0x1C and 0x1D give class SPECIAL (kind = 2) with spec_idx 0, 1 and 2. The value is sp_in, pc_in and ovf_in respectively.
- R8: Code 0x1E gives class MEM at address ext_word, with uses_ext = 1 and pc_next = pc_in + 1.
- R9: Code 0x1F gives class IMM (kind = 3) with value ext_word, uses_ext = 1, pc_next = pc_in + 1 and wr_discard = 1.
- R10: Codes 0x20 to 0x3F give class IMM with value code - 0x20 (0 to 31), wr_discard = 1 and uses_ext = 0.
- R11: Every code other than 0x10 to 0x17, 0x1E and 0x1F gives uses_ext = 0 and pc_next = pc_in. wr_discard is 1 only for class IMM. mem_rd is 1 only for class MEM.
- R12: sp_q is 0xFFFF after reset. On a rising clock edge with sp_commit = 1 it loads sp_next. With sp_commit = 0 it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 6 | Operand code to decode |
| gpr_flat | input | 128 | Eight 16-bit general registers, register k at bits 16k+15:16k |
| sp_in | input | 16 | Current stack pointer |
| pc_in | input | 16 | Program counter, pointing at the next code word |
| ovf_in | input | 16 | Overflow register |
| ext_word | input | 16 | Code word at pc_in |
| mem_rdata | input | 16 | Memory word read at mem_addr |
| sp_commit | input | 1 | Load sp_next into sp_q on this edge |
| opnd_kind | output | 2 | 0 GPR, 1 MEM, 2 SPECIAL, 3 IMM |
| gpr_idx | output | 3 | General register index |
| spec_idx | output | 2 | 0 SP, 1 PC, 2 overflow |
| mem_addr | output | 16 | Effective memory address |
| mem_rd | output | 1 | Operand lives in memory |
| opnd_value | output | 16 | Operand value |
| uses_ext | output | 1 | Following code word is consumed |
| pc_next | output | 16 | PC after operand decode |
| sp_next | output | 16 | SP after operand decode |
| wr_discard | output | 1 | Write-back to this operand must be dropped |
| sp_q | output | 16 | Committed stack pointer |

## Verification
The bench sweeps all 64 codes under two register patterns. One of them places the indexed sums and the stack moves on the 16-bit wrap. A design that carried into a 17th bit, or that pushed without pre-decrementing, would show a wrong address at 0x0000/0xFFFF. The bench watches the boundaries between code classes (0x07/0x08, 0x17/0x18, 0x1D/0x1E, 0x1F/0x20). An off-by-one in decode would misclassify the operand, drop the discard flag, or consume an extra word. Commit and hold sequences expose a stack register that moves on speculative reads or ignores the strobe.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int CODE_W = 6;

  typedef enum logic [1:0] {
    OK_GPR  = 2'd0,
    OK_MEM  = 2'd1,
    OK_SPEC = 2'd2,
    OK_IMM  = 2'd3
  } opnd_kind_e;

  typedef enum logic [3:0] {
    AM_REG,
    AM_IND,
    AM_IDX,
    AM_POP,
    AM_PEEK,
    AM_PUSH,
    AM_SPR,
    AM_EXTIND,
    AM_EXTIMM,
    AM_LIT
  } amode_e;
endpackage

// File: rtl/opdec_field_decode.sv
module opdec_field_decode
  import opdec_pkg::*;
#(
  parameter int NGPR = 8,
  localparam int IDXW = $clog2(NGPR)
) (
  input  logic [CODE_W-1:0] code,
  output amode_e            mode,
  output opnd_kind_e        kind,
  output logic [IDXW-1:0]   idx,
  output logic [1:0]        spec,
  output logic              uses_ext,
  output logic              discard
);
  always_comb begin
    mode     = AM_LIT;
    kind     = OK_IMM;
    spec     = 2'd0;
    uses_ext = 1'b0;
    idx      = code[IDXW-1:0];
    if (!code[5]) begin
      unique case (code[4:3])
        2'b00: begin mode = AM_REG; kind = OK_GPR; end
        2'b01: begin mode = AM_IND; kind = OK_MEM; end
        2'b10: begin mode = AM_IDX; kind = OK_MEM; uses_ext = 1'b1; end
        default: begin
          unique case (code[2:0])
            3'd0: begin mode = AM_POP;  kind = OK_MEM; end
            3'd1: begin mode = AM_PEEK; kind = OK_MEM; end
            3'd2: begin mode = AM_PUSH; kind = OK_MEM; end
            3'd3: begin mode = AM_SPR;  kind = OK_SPEC; spec = 2'd0; end
            3'd4: begin mode = AM_SPR;  kind = OK_SPEC; spec = 2'd1; end
            3'd5: begin mode = AM_SPR;  kind = OK_SPEC; spec = 2'd2; end
            3'd6: begin mode = AM_EXTIND; kind = OK_MEM; uses_ext = 1'b1; end
            default: begin mode = AM_EXTIMM; kind = OK_IMM; uses_ext = 1'b1; end
          endcase
        end
      endcase
    end
    discard = (mode == AM_LIT) || (mode == AM_EXTIMM);
  end
endmodule

// File: rtl/opdec_addr_gen.sv
module opdec_addr_gen
  import opdec_pkg::*;
#(
  parameter int W    = 16,
  parameter int NGPR = 8,
  localparam int IDXW = $clog2(NGPR)
) (
  input  amode_e           mode,
  input  logic [IDXW-1:0]  idx,
  input  logic [NGPR*W-1:0] gpr_flat,
  input  logic [W-1:0]     sp_in,
  input  logic [W-1:0]     pc_in,
  input  logic [W-1:0]     ext_word,
  input  logic             uses_ext,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     sp_next,
  output logic [W-1:0]     pc_next
);
  logic [W-1:0] gpr [NGPR];
  logic [W-1:0] base;
  logic [W-1:0] sp_dec;

  for (genvar g = 0; g < NGPR; g++) begin : g_unpack
    assign gpr[g] = gpr_flat[g*W +: W];
  end

  always_comb begin
    base    = gpr[idx];
    sp_dec  = sp_in - W'(1);
    sp_next = sp_in;
    unique case (mode)
      AM_IND:    mem_addr = base;
      AM_IDX:    mem_addr = base + ext_word;
      AM_POP:    begin mem_addr = sp_in; sp_next = sp_in + W'(1); end
      AM_PEEK:   mem_addr = sp_in;
      AM_PUSH:   begin mem_addr = sp_dec; sp_next = sp_dec; end
      AM_EXTIND: mem_addr = ext_word;
      default:   mem_addr = '0;
    endcase
    pc_next = pc_in + W'(uses_ext);
  end
endmodule

// File: rtl/opdec_value_mux.sv
module opdec_value_mux
  import opdec_pkg::*;
#(
  parameter int W    = 16,
  parameter int NGPR = 8,
  localparam int IDXW = $clog2(NGPR)
) (
  input  amode_e            mode,
  input  logic [CODE_W-1:0] code,
  input  logic [IDXW-1:0]   idx,
  input  logic [1:0]        spec,
  input  logic [NGPR*W-1:0] gpr_flat,
  input  logic [W-1:0]      sp_in,
  input  logic [W-1:0]      pc_in,
  input  logic [W-1:0]      ovf_in,
  input  logic [W-1:0]      ext_word,
  input  logic [W-1:0]      mem_rdata,
  output logic [W-1:0]      value
);
  logic [W-1:0] gpr [NGPR];
  logic [W-1:0] spr_val;

  for (genvar g = 0; g < NGPR; g++) begin : g_unpack
    assign gpr[g] = gpr_flat[g*W +: W];
  end

  always_comb begin
    unique case (spec)
      2'd0:    spr_val = sp_in;
      2'd1:    spr_val = pc_in;
      default: spr_val = ovf_in;
    endcase
    unique case (mode)
      AM_REG:    value = gpr[idx];
      AM_SPR:    value = spr_val;
      AM_EXTIMM: value = ext_word;
      AM_LIT:    value = {{(W-5){1'b0}}, code[4:0]};
      default:   value = mem_rdata;
    endcase
  end
endmodule

// File: rtl/operand_decoder.sv
module operand_decoder
  import opdec_pkg::*;
#(
  parameter int          W      = 16,
  parameter int          NGPR   = 8,
  parameter logic [15:0] SP_RST = 16'hFFFF,
  localparam int IDXW = $clog2(NGPR)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CODE_W-1:0]   op_code,
  input  logic [NGPR*W-1:0]   gpr_flat,
  input  logic [W-1:0]        sp_in,
  input  logic [W-1:0]        pc_in,
  input  logic [W-1:0]        ovf_in,
  input  logic [W-1:0]        ext_word,
  input  logic [W-1:0]        mem_rdata,
  input  logic                sp_commit,
  output logic [1:0]          opnd_kind,
  output logic [IDXW-1:0]     gpr_idx,
  output logic [1:0]          spec_idx,
  output logic [W-1:0]        mem_addr,
  output logic                mem_rd,
  output logic [W-1:0]        opnd_value,
  output logic                uses_ext,
  output logic [W-1:0]        pc_next,
  output logic [W-1:0]        sp_next,
  output logic                wr_discard,
  output logic [W-1:0]        sp_q
);
  amode_e     mode;
  opnd_kind_e kind;
  logic [W-1:0] sp_d;

  opdec_field_decode #(.NGPR(NGPR)) u_dec (
    .code     (op_code),
    .mode     (mode),
    .kind     (kind),
    .idx      (gpr_idx),
    .spec     (spec_idx),
    .uses_ext (uses_ext),
    .discard  (wr_discard)
  );

  opdec_addr_gen #(.W(W), .NGPR(NGPR)) u_addr (
    .mode     (mode),
    .idx      (gpr_idx),
    .gpr_flat (gpr_flat),
    .sp_in    (sp_in),
    .pc_in    (pc_in),
    .ext_word (ext_word),
    .uses_ext (uses_ext),
    .mem_addr (mem_addr),
    .sp_next  (sp_next),
    .pc_next  (pc_next)
  );

  opdec_value_mux #(.W(W), .NGPR(NGPR)) u_val (
    .mode      (mode),
    .code      (op_code),
    .idx       (gpr_idx),
    .spec      (spec_idx),
    .gpr_flat  (gpr_flat),
    .sp_in     (sp_in),
    .pc_in     (pc_in),
    .ovf_in    (ovf_in),
    .ext_word  (ext_word),
    .mem_rdata (mem_rdata),
    .value     (opnd_value)
  );

  assign opnd_kind = kind;
  assign mem_rd    = (kind == OK_MEM);

  // committed stack pointer: next-state and register kept apart
  always_comb begin
    sp_d = sp_q;
    if (sp_commit) sp_d = sp_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= W'(SP_RST);
    else        sp_q <= sp_d;
  end

  AST_LIT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    op_code[5] |-> (opnd_value == W'(op_code[4:0]) && wr_discard && !uses_ext)); // R10
  AST_EXT_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    uses_ext |-> (pc_next == pc_in + W'(1))); // R3
  AST_NOEXT_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !uses_ext |-> (pc_next == pc_in)); // R11
  AST_PUSH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 6'h1A) |-> (mem_addr == sp_in - W'(1) && sp_next == mem_addr)); // R6
  AST_POP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 6'h18) |-> (mem_addr == sp_in && sp_next == sp_in + W'(1))); // R4
  AST_SP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sp_commit |=> (sp_q == $past(sp_next))); // R12
  AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_commit |=> $stable(sp_q)); // R12
endmodule

// File: tb/tb_operand_decoder.sv
module tb_operand_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  op_code;
  logic [127:0] gpr_flat;
  logic [15:0] sp_in, pc_in, ovf_in, ext_word, mem_rdata;
  logic        sp_commit;
  logic [1:0]  opnd_kind;
  logic [2:0]  gpr_idx;
  logic [1:0]  spec_idx;
  logic [15:0] mem_addr, opnd_value, pc_next, sp_next, sp_q;
  logic        mem_rd, uses_ext, wr_discard;

  always #4 clk = ~clk;

  // fake memory: data depends on address only
  assign mem_rdata = mem_addr ^ 16'hA5A5;

  operand_decoder dut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .gpr_flat(gpr_flat),
    .sp_in(sp_in), .pc_in(pc_in), .ovf_in(ovf_in), .ext_word(ext_word),
    .mem_rdata(mem_rdata), .sp_commit(sp_commit), .opnd_kind(opnd_kind),
    .gpr_idx(gpr_idx), .spec_idx(spec_idx), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .opnd_value(opnd_value), .uses_ext(uses_ext),
    .pc_next(pc_next), .sp_next(sp_next), .wr_discard(wr_discard), .sp_q(sp_q)
  );

  typedef struct {
    logic [5:0]  code;
    logic [1:0]  kind;
    logic [15:0] addr;
    logic        mrd;
    logic [15:0] val;
    logic        ext;
    logic [15:0] pcn;
    logic [15:0] spn;
    logic        disc;
    logic [15:0] spq;
    logic [2:0]  gi;
    logic [1:0]  si;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [15:0] gpr [8];
  logic [15:0] model_spq;
  bit          driving_done = 0;

  function automatic string tag_of(logic [5:0] c);
    if (c < 6'h08) return "R1";
    if (c < 6'h10) return "R2";
    if (c < 6'h18) return "R3";
    if (c == 6'h18) return "R4";
    if (c == 6'h19) return "R5";
    if (c == 6'h1A) return "R6";
    if (c < 6'h1E) return "R7";
    if (c == 6'h1E) return "R8";
    if (c == 6'h1F) return "R9";
    return "R10";
  endfunction

  task automatic chk(string r, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic drive(logic [5:0] c, logic [15:0] sp, logic [15:0] pc,
                       logic [15:0] ov, logic [15:0] ex, logic cm);
    exp_t e;
    int   ci;
    @(negedge clk);
    for (int k = 0; k < 8; k++) gpr_flat[k*16 +: 16] = gpr[k];
    op_code = c; sp_in = sp; pc_in = pc; ovf_in = ov; ext_word = ex; sp_commit = cm;
    ci = int'(c);
    e.code = c; e.tag = tag_of(c);
    e.gi = c[2:0]; e.si = 2'(ci - 27);
    e.addr = 16'h0; e.ext = 1'b0; e.spn = sp;
    if (ci >= 32 || ci == 31) e.kind = 2'd3;
    else if (ci < 8) e.kind = 2'd0;
    else if (ci >= 27 && ci <= 29) e.kind = 2'd2;
    else e.kind = 2'd1;
    if (ci >= 8 && ci < 16) e.addr = gpr[ci-8];
    if (ci >= 16 && ci < 24) begin e.addr = gpr[ci-16] + ex; e.ext = 1'b1; end
    if (ci == 24) begin e.addr = sp; e.spn = sp + 16'd1; end
    if (ci == 25) e.addr = sp;
    if (ci == 26) begin e.addr = sp - 16'd1; e.spn = sp - 16'd1; end
    if (ci == 30) begin e.addr = ex; e.ext = 1'b1; end
    if (ci == 31) e.ext = 1'b1;
    e.mrd = (e.kind == 2'd1);
    case (e.kind)
      2'd0: e.val = gpr[ci];
      2'd1: e.val = e.addr ^ 16'hA5A5;
      2'd2: e.val = (ci == 27) ? sp : (ci == 28) ? pc : ov;
      default: e.val = (ci == 31) ? ex : 16'(ci - 32);
    endcase
    e.pcn = pc + {15'd0, e.ext};
    e.disc = (e.kind == 2'd3);
    e.spq = model_spq;
    if (cm) model_spq = e.spn;
    sb.push_back(e);
  endtask

  // monitor: compares each expected item against the outputs
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "kind", {14'd0, opnd_kind}, {14'd0, e.kind});
        chk(e.tag, "value", opnd_value, e.val);
        chk("R11", "mem_rd", {15'd0, mem_rd}, {15'd0, e.mrd});
        if (e.mrd) chk(e.tag, "mem_addr", mem_addr, e.addr);
        if (e.kind == 2'd0) chk("R1", "gpr_idx", {13'd0, gpr_idx}, {13'd0, e.gi});
        if (e.kind == 2'd2) chk("R7", "spec_idx", {14'd0, spec_idx}, {14'd0, e.si});
        chk(e.ext ? e.tag : "R11", "uses_ext", {15'd0, uses_ext}, {15'd0, e.ext});
        chk(e.ext ? e.tag : "R11", "pc_next", pc_next, e.pcn);
        chk(e.tag, "sp_next", sp_next, e.spn);
        chk(e.disc ? e.tag : "R11", "wr_discard", {15'd0, wr_discard}, {15'd0, e.disc});
        chk("R12", "sp_q", sp_q, e.spq);
      end
    end
  end

  initial begin
    rst_n = 1'b0; op_code = 6'h0; gpr_flat = '0; sp_in = 16'h0; pc_in = 16'h0;
    ovf_in = 16'h0; ext_word = 16'h0; sp_commit = 1'b0;
    model_spq = 16'hFFFF;
    for (int k = 0; k < 8; k++) gpr[k] = 16'h0;
    repeat (3) @(negedge clk);
    #2;
    chk("R12", "sp_q in reset", sp_q, 16'hFFFF);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R12", "sp_q after reset", sp_q, 16'hFFFF);

    // pattern A: plain values, all codes
    for (int k = 0; k < 8; k++) gpr[k] = 16'h1000 + 16'(k * 16'h0111);
    for (int c = 0; c < 64; c++) drive(6'(c), 16'h8000, 16'h0100, 16'h1234, 16'h0040, 1'b0);

    // pattern B: indexed sums and push on the wrap
    for (int k = 0; k < 8; k++) gpr[k] = 16'hFFF0 + 16'(k);
    for (int c = 0; c < 64; c++) drive(6'(c), 16'h0000, 16'hFFFF, 16'hBEEF, 16'h0020, 1'b0);

    // pop from 0xFFFF wraps to 0
    drive(6'h18, 16'hFFFF, 16'h0200, 16'h0, 16'h0, 1'b0);

    // commit sequences for the stack register
    drive(6'h1A, 16'h4000, 16'h0300, 16'h0, 16'h0, 1'b1);
    drive(6'h05, 16'h3FFF, 16'h0301, 16'h0, 16'h0, 1'b0);
    drive(6'h18, 16'h1000, 16'h0302, 16'h0, 16'h0, 1'b0);
    drive(6'h18, 16'h1000, 16'h0303, 16'h0, 16'h0, 1'b1);
    drive(6'h19, 16'h2222, 16'h0304, 16'h0, 16'h0, 1'b1);
    drive(6'h1A, 16'h0000, 16'h0305, 16'h0, 16'h0, 1'b1);
    drive(6'h3F, 16'h7777, 16'h0306, 16'h0, 16'h0, 1'b0);
    drive(6'h00, 16'h7777, 16'h0307, 16'h0, 16'h0, 1'b0);

    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    driving_done = 1;
  end

  initial begin
    fork
      begin
        wait (driving_done);
      end
      begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule